// File: doc/BRIEF.md
# Sign-Magnitude Signed Multiplier

This combinational block multiplies two two's-complement operands and returns their full-width signed product. Each operand first passes through a magnitude stage: a two's-complement negator and a 2:1 select, steered by the operand's own sign bit. This stage gives the unsigned core two non-negative values.

The core builds one partial product per multiplier bit and adds them. A final stage negates the core result only when the two input signs differ. The default operand width is 8 bits, which gives a 16-bit product.

The most negative operand code (8'h80, decimal -128) has no positive counterpart in the operand width. Results are only guaranteed for operands from -127 to +127. The block raises a flag whenever either input holds that code, and the product is then unspecified.

Top module: `smul_signmag`

## Requirements
- R1: For operands in -127..+127 (two's complement, bit 7 is the sign), prod_o equals the exact signed product mcand_i * mplier_i as a 16-bit two's-complement value.
- R2: range_err_o is 1 exactly when mcand_i or mplier_i equals 8'h80, and is 0 otherwise.
- R3: With range_err_o low, prod_o lies between -16129 (16'hC0FF) and +16129 (16'h3F01) inclusive.
- R4: With range_err_o low, a zero on either operand gives prod_o = 16'h0000, whatever the sign of the other operand.
- R5: With range_err_o low and a non-zero product, prod_o bit 15 equals mcand_i bit 7 XOR mplier_i bit 7.
- R6: With range_err_o low, swapping mcand_i and mplier_i leaves prod_o unchanged.
- R7: Multiplying by +1 returns the other operand sign-extended to 16 bits. Multiplying by -1 (8'hFF) returns its 16-bit negation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand_i | input | 8 | Signed multiplicand, two's complement |
| mplier_i | input | 8 | Signed multiplier, two's complement |
| prod_o | output | 16 | Signed product, two's complement |
| range_err_o | output | 1 | Set when either operand is the unconvertible code 8'h80 |

## Verification
Every pair of 8-bit codes is applied, and each result is compared with a signed product computed in the bench. This catches a magnitude stage that selects on the wrong sign or forgets the +1 of the complement, because every negative operand then gives a product that is off by one operand. It also catches an output stage keyed on a single sign instead of the XOR, because like-signed negative pairs then come out negative.

The -128 code is swept against all partners to check that the flag is neither missed nor raised on a neighbouring code such as 8'h81. Directed checks cover the zero operand with a negative partner, where a stray negation would still be harmless but a wrong carry would not. They also cover the ±1 identities and the two range extremes, ±127 × ±127, where a truncated adder chain loses the top product bit.

// File: rtl/smul_pkg.sv
package smul_pkg;
  localparam int unsigned OP_W_DEF = 8;

  function automatic int unsigned prod_width(int unsigned op_w);
    return 2 * op_w;
  endfunction
endpackage

// File: rtl/smul_magnitude.sv
module smul_magnitude #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] mag_o,
  output logic         neg_o
);
  logic [W-1:0] cpl;

  assign neg_o = val_i[W-1];
  assign cpl   = ~val_i + {{(W-1){1'b0}}, 1'b1};
  // 8'h80 maps to itself; read unsigned it is 128
  assign mag_o = neg_o ? cpl : val_i;
endmodule

// File: rtl/smul_uarray.sv
module smul_uarray #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] prod_o
);
  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] pp  [W];
  logic [PW-1:0] acc [W+1];

  assign acc[0] = '0;

  for (genvar i = 0; i < W; i++) begin : g_row
    logic [PW-1:0] ext;
    assign ext    = {{W{1'b0}}, mcand_i};
    assign pp[i]  = mplier_i[i] ? (ext << i) : '0;
    assign acc[i+1] = acc[i] + pp[i];
  end

  assign prod_o = acc[W];
endmodule

// File: rtl/smul_sign_fix.sv
module smul_sign_fix #(
  parameter int unsigned PW = 16
) (
  input  logic [PW-1:0] mag_i,
  input  logic          flip_i,
  output logic [PW-1:0] res_o
);
  logic [PW-1:0] cpl;

  assign cpl   = ~mag_i + {{(PW-1){1'b0}}, 1'b1};
  assign res_o = flip_i ? cpl : mag_i;
endmodule

// File: rtl/smul_signmag.sv
module smul_signmag
  import smul_pkg::*;
#(
  parameter int unsigned W = OP_W_DEF
) (
  input  logic [W-1:0]              mcand_i,
  input  logic [W-1:0]              mplier_i,
  output logic [prod_width(W)-1:0]  prod_o,
  output logic                      range_err_o
);
  localparam int unsigned PW = prod_width(W);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0]  mag_a, mag_b;
  logic          neg_a, neg_b;
  logic [PW-1:0] umag;

  smul_magnitude #(.W(W)) u_mag_a (.val_i(mcand_i),  .mag_o(mag_a), .neg_o(neg_a));
  smul_magnitude #(.W(W)) u_mag_b (.val_i(mplier_i), .mag_o(mag_b), .neg_o(neg_b));

  smul_uarray #(.W(W)) u_array (
    .mcand_i (mag_a),
    .mplier_i(mag_b),
    .prod_o  (umag)
  );

  smul_sign_fix #(.PW(PW)) u_fix (
    .mag_i (umag),
    .flip_i(neg_a ^ neg_b),
    .res_o (prod_o)
  );

  assign range_err_o = (mcand_i == MOST_NEG) || (mplier_i == MOST_NEG);
endmodule

// File: rtl/smul_signmag_chk.sv
module smul_signmag_chk #(
  parameter int unsigned W = 8
) (
  input logic [W-1:0]   mcand_i,
  input logic [W-1:0]   mplier_i,
  input logic [2*W-1:0] prod_o,
  input logic           range_err_o
);
  localparam int LIM = ((1 << (W-1)) - 1) * ((1 << (W-1)) - 1);

  always_comb begin
    if (!range_err_o) begin
      AST_EXACT_PRODUCT: assert ($signed(prod_o) == $signed(mcand_i) * $signed(mplier_i)); // R1
      AST_NO_OVERFLOW: assert ($signed(prod_o) <= LIM && $signed(prod_o) >= -LIM); // R3
      if (mcand_i == '0 || mplier_i == '0)
        AST_ZERO_OPERAND: assert (prod_o == '0); // R4
      if (prod_o != '0)
        AST_SIGN_RULE: assert (prod_o[2*W-1] == (mcand_i[W-1] ^ mplier_i[W-1])); // R5
    end
    if (!mcand_i[W-1] && !mplier_i[W-1])
      AST_FLAG_CLEAR_POS: assert (!range_err_o); // R2
  end
endmodule

bind smul_signmag smul_signmag_chk #(.W(W)) u_chk (
  .mcand_i    (mcand_i),
  .mplier_i   (mplier_i),
  .prod_o     (prod_o),
  .range_err_o(range_err_o)
);

// File: tb/smul_signmag_bench.sv
module smul_signmag_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  a_s = '0, b_s = '0;
  logic [15:0] prod;
  logic        rerr;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  smul_signmag u_smul_signmag (
    .mcand_i(a_s), .mplier_i(b_s), .prod_o(prod), .range_err_o(rerr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req,
               $signed(a_s), $signed(b_s), act, exp);
    end
  endtask

  task automatic apply(input int a, input int b);
    @(posedge clk);
    a_s = a[7:0];
    b_s = b[7:0];
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R4 reset-state product", int'($signed(prod)), 0);
    chk("R2 reset-state flag", int'(rerr), 0);

    for (int a = -128; a < 128; a++) begin
      for (int b = -128; b < 128; b++) begin
        apply(a, b);
        if (a == -128 || b == -128) begin
          chk("R2 flag on 8'h80", int'(rerr), 1);
        end else begin
          chk("R1 exact product", int'($signed(prod)), a * b);
          if (rerr) chk("R2 flag clear", int'(rerr), 0);
          if ($signed(prod) > 16129 || $signed(prod) < -16129)
            chk("R3 range", int'($signed(prod)), a * b);
        end
      end
    end

    // R4 zero with negative partner
    apply(0, -127);  chk("R4 zero x -127", int'($signed(prod)), 0);
    apply(-1, 0);    chk("R4 -1 x zero", int'($signed(prod)), 0);
    // R5 sign cases
    apply(-5, -7);   chk("R5 neg x neg sign", int'(prod[15]), 0);
    apply(-5, 7);    chk("R5 neg x pos sign", int'(prod[15]), 1);
    apply(5, -7);    chk("R5 pos x neg sign", int'(prod[15]), 1);
    // R6 commutation
    for (int k = 0; k < 8; k++) begin
      int x, y, p1;
      x = (k * 37) - 127;
      y = 113 - (k * 29);
      apply(x, y); p1 = int'($signed(prod));
      apply(y, x); chk("R6 swap", int'($signed(prod)), p1);
    end
    // R7 identities
    apply(1, -100);  chk("R7 +1 identity", int'(prod), 16'hFF9C);
    apply(-1, 100);  chk("R7 -1 negation", int'($signed(prod)), -100);
    apply(-127, -1); chk("R7 -1 x -127", int'($signed(prod)), 127);
    // R3 extremes
    apply(127, 127);  chk("R3 max", int'(prod), 16'h3F01);
    apply(-127, 127); chk("R3 min", int'(prod), 16'hC0FF);
    apply(-127, -127); chk("R3 neg max", int'(prod), 16'h3F01);
    // R2 neighbours of 8'h80
    apply(-127, 5);  chk("R2 8'h81 no flag", int'(rerr), 0);
    apply(127, -128); chk("R2 8'h80 flag", int'(rerr), 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule